// File: doc/BRIEF.md
# Parallel SAR Converter Host Controller

This block runs an external 16-bit successive-approximation converter that returns its result on a parallel bus. Working from the system clock, it produces the converter's clock, chip select, conversion strobe, read strobe and byte-select. It follows the converter's busy flag through a synchroniser and reads the finished result. It does so either as one full-width read or, on an 8-bit bus, as two reads that are joined into one word.

On the user side, a single-cycle `start_i` requests one conversion and a level on `run_i` repeats conversions back to back. `byte_mode_i` is sampled when each conversion begins and selects the read style. Every result leaves on `sample_o` with a one-cycle `sample_vld_o`. If the busy flag never completes its high-then-low cycle within a bounded time, the controller gives up on that conversion, releases the bus and pulses `timeout_o`.

Every minimum time the converter needs is a parameter counted in system-clock cycles. The defaults suit a 4 ns system clock. The converter clock has 52 ns high and low phases. The conversion strobe stays low for 24 ns and leads a converter-clock rise by at least 12 ns. Each read pulse is 52 ns wide, with at least 24 ns high between the two halves of a byte read. At least 128 ns pass between the last read and the next conversion strobe.

Top module: `sar_adc_host`

## Requirements
- R1: While reset is held, and in the first cycle after it, `adc_cs_n_o`, `adc_convst_n_o` and `adc_rd_n_o` are 1, and `adc_byte_o`, `sample_vld_o` and `timeout_o` are 0.
- R2: `adc_clk_o` runs continuously. Each high phase lasts exactly CCLK_HI_CYC cycles and each low phase exactly CCLK_LO_CYC cycles (13 and 13 by default).
- R3: `adc_cs_n_o` falls at least CS_SETUP_CYC cycles before `adc_convst_n_o` falls, and stays low until the read sequence ends.
- R4: `adc_convst_n_o` falls only while `adc_clk_o` is low, at least CONV_LEAD_CYC cycles before the next rise of `adc_clk_o`. It then stays low for exactly CONV_LO_CYC cycles.
- R5: A read (`adc_rd_n_o` low) starts only after the synchronised busy flag has gone high and then low again. The read strobe stays high during the conversion.
- R6: With the mode input at 0 (word mode), one read is made. It is CONV..RD_LO_CYC cycles low, `adc_byte_o` stays 0, and `sample_o` equals `adc_db_i[15:0]` as seen in the last low cycle of the read.
- R7: With the mode input at 1 (byte mode), two reads are made. The first has `adc_byte_o`=0 and its `adc_db_i[7:0]` becomes `sample_o[7:0]`. `adc_byte_o` then rises together with the read strobe, which stays high for RD_HI_CYC cycles. The second read has `adc_byte_o`=1 and its `adc_db_i[7:0]` becomes `sample_o[15:8]`.
- R8: `sample_vld_o` is high for exactly one cycle per completed conversion, and `sample_o` is valid in that cycle.
- R9: At least GAP_CYC cycles pass between the rise of the last read strobe and the next fall of `adc_convst_n_o`. `start_i` is ignored while a conversion or read sequence is in progress.
- R10: While `run_i` is high, conversions follow one another with no `start_i` pulses. Each delivers its own result.
- R11: If the busy flag has not both risen and fallen within BUSY_TMO_CYC cycles after the conversion strobe rises, `timeout_o` pulses for one cycle. In that case no read is made, no valid pulse is given and chip select returns high.
- R12: The mode is captured when a conversion is accepted. A change of `byte_mode_i` during the conversion does not change the number of reads or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request for one conversion |
| run_i | input | 1 | Level: repeat conversions back to back |
| byte_mode_i | input | 1 | 0 = one 16-bit read, 1 = two 8-bit reads |
| sample_o | output | DATA_W | Last assembled result |
| sample_vld_o | output | 1 | One-cycle pulse when sample_o is new |
| timeout_o | output | 1 | One-cycle pulse when busy never completed |
| adc_clk_o | output | 1 | Converter clock |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_convst_n_o | output | 1 | Conversion start strobe, active low |
| adc_rd_n_o | output | 1 | Read strobe, active low |
| adc_byte_o | output | 1 | Byte select: 0 low byte / full word, 1 upper byte |
| adc_busy_i | input | 1 | Converter busy flag (asynchronous) |
| adc_db_i | input | DATA_W | Converter parallel data bus |

## Verification
The assertions assume that the converter raises its busy flag soon after the conversion strobe falls and keeps it low outside a conversion. They also assume that the flag is already low again whenever a read strobe falls, so that a read never overlaps a real conversion. The bench's converter model follows this. It raises busy 9 ns after the strobe falls and drops it 7 ns after the sixteenth converter-clock rise. Data appear 11 ns after the read strobe and chip select are both low. In the stuck case, busy rises and then stays high. Every model delay is an odd number of nanoseconds past a system-clock rise, so no input changes at a sampling edge.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETUP,
      ST_ALIGN,
      ST_CONV,
      ST_WAIT_HI,
      ST_WAIT_LO,
      ST_RD_LO,
      ST_RD_HI,
      ST_GAP
   } host_state_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sar_host_sync.sv
module sar_host_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sar_host_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sar_host_cclk.sv
module sar_host_cclk #(
   parameter int HI_CYC   = 13,
   parameter int LO_CYC   = 13,
   parameter int LEAD_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic cclk_o,
   output logic lead_ok_o
);
   localparam int PH_MAX = sar_host_pkg::max_of(HI_CYC, LO_CYC);
   localparam int PH_W   = $clog2(PH_MAX + 1);

   logic            cclk_q;
   logic [PH_W-1:0] ph_cnt_q;

   generate
      if (HI_CYC < 2 || LO_CYC < 2) begin : g_bad_phase
         $error("sar_host_cclk: each phase needs at least 2 cycles");
      end
      if (LEAD_CYC < 1 || LEAD_CYC >= LO_CYC) begin : g_bad_lead
         $error("sar_host_cclk: LEAD_CYC must lie in 1..LO_CYC-1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cclk_q   <= 1'b0;
         ph_cnt_q <= PH_W'(LO_CYC - 1);
      end else if (ph_cnt_q == '0) begin
         cclk_q   <= ~cclk_q;
         ph_cnt_q <= cclk_q ? PH_W'(LO_CYC - 1) : PH_W'(HI_CYC - 1);
      end else begin
         ph_cnt_q <= ph_cnt_q - 1'b1;
      end
   end

   // Low phase with enough cycles left before the next rise.
   assign lead_ok_o = !cclk_q && (ph_cnt_q >= PH_W'(LEAD_CYC));
   assign cclk_o    = cclk_q;
endmodule

// File: rtl/sar_host_seq.sv
module sar_host_seq
   import sar_host_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int CS_SETUP_CYC = 2,
   parameter int CONV_LO_CYC  = 6,
   parameter int RD_LO_CYC    = 13,
   parameter int RD_HI_CYC    = 6,
   parameter int GAP_CYC      = 32,
   parameter int BUSY_TMO_CYC = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              run_i,
   input  logic              byte_mode_i,
   input  logic              lead_ok_i,
   input  logic              busy_s_i,
   input  logic [DATA_W-1:0] db_i,
   output logic              cs_n_o,
   output logic              convst_n_o,
   output logic              rd_n_o,
   output logic              byte_o,
   output logic [DATA_W-1:0] sample_o,
   output logic              vld_o,
   output logic              tmo_o
);
   localparam int HALF_W  = DATA_W / 2;
   localparam int CNT_MAX = max_of(max_of(BUSY_TMO_CYC, GAP_CYC),
                                   max_of(max_of(RD_LO_CYC, RD_HI_CYC),
                                          max_of(CS_SETUP_CYC, CONV_LO_CYC)));
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   host_state_t       st_q, st_nx;
   logic [CNT_W-1:0]  cnt_q, cnt_nx;
   logic              half_q, half_nx;
   logic              mode_q, mode_nx;
   logic              cap_lo, cap_hi, cap_word;
   logic              vld_nx, tmo_nx;
   logic [DATA_W-1:0] smp_q;

   always_comb begin
      st_nx    = st_q;
      cnt_nx   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
      half_nx  = half_q;
      mode_nx  = mode_q;
      cap_lo   = 1'b0;
      cap_hi   = 1'b0;
      cap_word = 1'b0;
      vld_nx   = 1'b0;
      tmo_nx   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i || run_i) begin
               st_nx   = ST_SETUP;
               cnt_nx  = CNT_W'(CS_SETUP_CYC - 1);
               mode_nx = byte_mode_i;
            end
         end
         ST_SETUP: begin
            if (cnt_q == '0) st_nx = ST_ALIGN;
         end
         ST_ALIGN: begin
            if (lead_ok_i) begin
               st_nx  = ST_CONV;
               cnt_nx = CNT_W'(CONV_LO_CYC - 1);
            end
         end
         ST_CONV: begin
            if (cnt_q == '0) begin
               st_nx  = ST_WAIT_HI;
               cnt_nx = CNT_W'(BUSY_TMO_CYC - 1);
            end
         end
         ST_WAIT_HI: begin
            if (busy_s_i) begin
               st_nx = ST_WAIT_LO;
            end else if (cnt_q == '0) begin
               st_nx  = ST_GAP;
               cnt_nx = CNT_W'(GAP_CYC - 1);
               tmo_nx = 1'b1;
            end
         end
         ST_WAIT_LO: begin
            if (!busy_s_i) begin
               st_nx   = ST_RD_LO;
               cnt_nx  = CNT_W'(RD_LO_CYC - 1);
               half_nx = 1'b0;
            end else if (cnt_q == '0) begin
               st_nx  = ST_GAP;
               cnt_nx = CNT_W'(GAP_CYC - 1);
               tmo_nx = 1'b1;
            end
         end
         ST_RD_LO: begin
            if (cnt_q == '0) begin
               if (mode_q && !half_q) begin
                  cap_lo  = 1'b1;
                  st_nx   = ST_RD_HI;
                  cnt_nx  = CNT_W'(RD_HI_CYC - 1);
                  half_nx = 1'b1;
               end else begin
                  cap_hi   = mode_q;
                  cap_word = !mode_q;
                  st_nx    = ST_GAP;
                  cnt_nx   = CNT_W'(GAP_CYC - 1);
                  half_nx  = 1'b0;
                  vld_nx   = 1'b1;
               end
            end
         end
         ST_RD_HI: begin
            if (cnt_q == '0) begin
               st_nx  = ST_RD_LO;
               cnt_nx = CNT_W'(RD_LO_CYC - 1);
            end
         end
         ST_GAP: begin
            if (cnt_q == '0) st_nx = ST_IDLE;
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         cnt_q      <= '0;
         half_q     <= 1'b0;
         mode_q     <= 1'b0;
         cs_n_o     <= 1'b1;
         convst_n_o <= 1'b1;
         rd_n_o     <= 1'b1;
         vld_o      <= 1'b0;
         tmo_o      <= 1'b0;
      end else begin
         st_q       <= st_nx;
         cnt_q      <= cnt_nx;
         half_q     <= half_nx;
         mode_q     <= mode_nx;
         cs_n_o     <= (st_nx == ST_IDLE) || (st_nx == ST_GAP);
         convst_n_o <= (st_nx != ST_CONV);
         rd_n_o     <= (st_nx != ST_RD_LO);
         vld_o      <= vld_nx;
         tmo_o      <= tmo_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_q <= '0;
      end else if (cap_word) begin
         smp_q <= db_i;
      end else if (cap_lo) begin
         smp_q[HALF_W-1:0] <= db_i[HALF_W-1:0];
      end else if (cap_hi) begin
         smp_q[DATA_W-1:HALF_W] <= db_i[HALF_W-1:0];
      end
   end

   assign byte_o   = half_q;
   assign sample_o = smp_q;
endmodule

// File: rtl/sar_adc_host.sv
module sar_adc_host #(
   parameter int DATA_W       = 16,
   parameter int SYNC_STAGES  = 2,
   parameter int CCLK_HI_CYC  = 13,
   parameter int CCLK_LO_CYC  = 13,
   parameter int CS_SETUP_CYC = 2,
   parameter int CONV_LO_CYC  = 6,
   parameter int CONV_LEAD_CYC = 3,
   parameter int RD_LO_CYC    = 13,
   parameter int RD_VALID_CYC = 10,
   parameter int RD_HI_CYC    = 6,
   parameter int GAP_CYC      = 32,
   parameter int BUSY_TMO_CYC = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              run_i,
   input  logic              byte_mode_i,
   output logic [DATA_W-1:0] sample_o,
   output logic              sample_vld_o,
   output logic              timeout_o,
   output logic              adc_clk_o,
   output logic              adc_cs_n_o,
   output logic              adc_convst_n_o,
   output logic              adc_rd_n_o,
   output logic              adc_byte_o,
   input  logic              adc_busy_i,
   input  logic [DATA_W-1:0] adc_db_i
);
   generate
      if (DATA_W < 2 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("sar_adc_host: DATA_W must be even and at least 2");
      end
      if (RD_LO_CYC <= RD_VALID_CYC) begin : g_bad_read
         $error("sar_adc_host: read pulse shorter than data-valid delay");
      end
      if (CS_SETUP_CYC < 1 || CONV_LO_CYC < 1 || RD_HI_CYC < 1 ||
          GAP_CYC < 1 || BUSY_TMO_CYC < 2) begin : g_bad_count
         $error("sar_adc_host: timing counts must be positive");
      end
   endgenerate

   logic lead_ok;
   logic busy_s;

   sar_host_cclk #(
      .HI_CYC  (CCLK_HI_CYC),
      .LO_CYC  (CCLK_LO_CYC),
      .LEAD_CYC(CONV_LEAD_CYC)
   ) u_cclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .cclk_o   (adc_clk_o),
      .lead_ok_o(lead_ok)
   );

   sar_host_sync #(
      .STAGES(SYNC_STAGES)
   ) u_busy_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (adc_busy_i),
      .q_o  (busy_s)
   );

   sar_host_seq #(
      .DATA_W      (DATA_W),
      .CS_SETUP_CYC(CS_SETUP_CYC),
      .CONV_LO_CYC (CONV_LO_CYC),
      .RD_LO_CYC   (RD_LO_CYC),
      .RD_HI_CYC   (RD_HI_CYC),
      .GAP_CYC     (GAP_CYC),
      .BUSY_TMO_CYC(BUSY_TMO_CYC)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .run_i      (run_i),
      .byte_mode_i(byte_mode_i),
      .lead_ok_i  (lead_ok),
      .busy_s_i   (busy_s),
      .db_i       (adc_db_i),
      .cs_n_o     (adc_cs_n_o),
      .convst_n_o (adc_convst_n_o),
      .rd_n_o     (adc_rd_n_o),
      .byte_o     (adc_byte_o),
      .sample_o   (sample_o),
      .vld_o      (sample_vld_o),
      .tmo_o      (timeout_o)
   );
endmodule

// File: rtl/sar_adc_host_chk.sv
module sar_adc_host_chk #(
   parameter int CCLK_HI_CYC   = 13,
   parameter int CCLK_LO_CYC   = 13,
   parameter int CONV_LEAD_CYC = 3,
   parameter int GAP_CYC       = 32,
   parameter int POST_CYC      = 3
) (
   input logic clk,
   input logic rst_n,
   input logic adc_clk_o,
   input logic adc_cs_n_o,
   input logic adc_convst_n_o,
   input logic adc_rd_n_o,
   input logic adc_byte_o,
   input logic adc_busy_i,
   input logic sample_vld_o,
   input logic timeout_o
);
   logic        clk_prev;
   logic [7:0]  run_len;
   logic        cv_prev, rd_prev;
   logic [7:0]  since_cf;
   logic [15:0] since_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_prev <= 1'b0;
         run_len  <= '0;
         cv_prev  <= 1'b1;
         rd_prev  <= 1'b1;
         since_cf <= '1;
         since_rd <= '1;
      end else begin
         clk_prev <= adc_clk_o;
         run_len  <= (adc_clk_o == clk_prev) ? run_len + 1'b1 : 8'd1;
         cv_prev  <= adc_convst_n_o;
         rd_prev  <= adc_rd_n_o;
         if (!adc_convst_n_o && cv_prev)  since_cf <= 8'd1;
         else if (since_cf != '1)         since_cf <= since_cf + 1'b1;
         if (adc_rd_n_o && !rd_prev)      since_rd <= 16'd1;
         else if (since_rd != '1)         since_rd <= since_rd + 1'b1;
      end
   end

   a_r2_clk_phase_width: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_clk_o != clk_prev) |-> (run_len == (clk_prev ? 8'(CCLK_HI_CYC) : 8'(CCLK_LO_CYC))));

   a_r3_cs_leads_convst: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_convst_n_o) |-> (!adc_cs_n_o && $past(!adc_cs_n_o)));

   a_r4_convst_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_convst_n_o) |-> !adc_clk_o);

   a_r4_convst_edge_lead: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_clk_o) |-> (since_cf >= 8'(CONV_LEAD_CYC)));

   a_r5_read_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_rd_n_o |-> (!adc_cs_n_o && adc_convst_n_o));

   a_r5_read_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_rd_n_o) |-> !adc_busy_i);

   a_r7_byte_steady_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!adc_rd_n_o && $past(!adc_rd_n_o)) |-> $stable(adc_byte_o));

   a_r8_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      sample_vld_o |=> !sample_vld_o);

   a_r9_read_to_convst_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_convst_n_o) |-> (since_rd >= 16'(GAP_CYC)));

   a_r9_post_convst_keepout: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_rd_n_o) |-> (since_cf >= 8'(POST_CYC)));

   a_r11_timeout_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (!sample_vld_o && adc_rd_n_o));
endmodule

bind sar_adc_host sar_adc_host_chk #(
   .CCLK_HI_CYC  (CCLK_HI_CYC),
   .CCLK_LO_CYC  (CCLK_LO_CYC),
   .CONV_LEAD_CYC(CONV_LEAD_CYC),
   .GAP_CYC      (GAP_CYC)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .adc_clk_o     (adc_clk_o),
   .adc_cs_n_o    (adc_cs_n_o),
   .adc_convst_n_o(adc_convst_n_o),
   .adc_rd_n_o    (adc_rd_n_o),
   .adc_byte_o    (adc_byte_o),
   .adc_busy_i    (adc_busy_i),
   .sample_vld_o  (sample_vld_o),
   .timeout_o     (timeout_o)
);

// File: tb/sar_adc_host_bench.sv
`timescale 1ns/1ps
module sar_adc_host_bench;
   localparam int HI = 13, LO = 13, CSS = 2, CVL = 6, LEAD = 3;
   localparam int RDL = 13, RDH = 6, GAP = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, run = 1'b0, bmode = 1'b0;
   logic adc_clk, cs_n, convst_n, rd_n, byte_sel;
   logic busy = 1'b0;
   logic [15:0] db, sample;
   logic vld, tmo;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   sar_adc_host u_sar_adc_host (
      .clk(clk), .rst_n(rst_n), .start_i(start), .run_i(run), .byte_mode_i(bmode),
      .sample_o(sample), .sample_vld_o(vld), .timeout_o(tmo),
      .adc_clk_o(adc_clk), .adc_cs_n_o(cs_n), .adc_convst_n_o(convst_n),
      .adc_rd_n_o(rd_n), .adc_byte_o(byte_sel), .adc_busy_i(busy), .adc_db_i(db)
   );

   // ---------------- converter model ----------------
   logic [15:0] code = 16'h0, incr = 16'h0, out_word = 16'h0;
   bit stuck = 0, active = 0;
   int rises = 0;

   always @(negedge convst_n) begin
      if (rst_n && !cs_n) begin
         rises  = 0;
         active = 1;
         #9 busy = 1'b1;
      end
   end

   always @(posedge adc_clk) begin
      if (active) begin
         rises++;
         if (rises == 16 && !stuck) begin
            active = 0;
            #7;
            out_word = code;
            code     = code + incr;
            busy     = 1'b0;
         end
      end
   end

   assign #11 db = (!cs_n && !rd_n) ? (byte_sel ? {8'h3C, out_word[15:8]} : out_word)
                                    : 16'h5AC3;

   // ---------------- pin monitor ----------------
   logic p_cv = 1'b1, p_rd = 1'b1, p_clk = 1'b0;
   int cf_cnt, rd_falls, vld_cnt, tmo_cnt, cs_run, cs_min, since_rd, gap_min;
   int lead_cnt, lead_min, cvl_len, cvl_last, rdl_len, rdl_min, rdl_max;
   int rdh_len, rdh_min, rd_busy;
   bit lead_armed;
   logic byte0, byte1;
   logic [15:0] smp [0:3];

   task automatic clr();
      cf_cnt = 0; rd_falls = 0; vld_cnt = 0; tmo_cnt = 0;
      cs_min = 100000; gap_min = 100000; lead_min = 1000; lead_armed = 0;
      cvl_last = 0; rdl_min = 1000; rdl_max = 0; rdh_min = 1000; rd_busy = 0;
      byte0 = 1'b0; byte1 = 1'b0;
   endtask

   initial begin
      clr();
      since_rd = 100000; cs_run = 0; cvl_len = 0; rdl_len = 0; rdh_len = 0; lead_cnt = 0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         cs_run = cs_n ? 0 : cs_run + 1;
         if (lead_armed) begin
            lead_cnt++;
            if (!p_clk && adc_clk) begin
               if (lead_cnt < lead_min) lead_min = lead_cnt;
               lead_armed = 0;
            end
         end
         if (!convst_n) cvl_len++;
         if (p_cv && !convst_n) begin
            cf_cnt++;
            if (cs_run < cs_min) cs_min = cs_run;
            if (since_rd < gap_min) gap_min = since_rd;
            lead_armed = 1; lead_cnt = 0;
         end
         if (!p_cv && convst_n) begin
            cvl_last = cvl_len; cvl_len = 0;
         end
         if (p_rd && !rd_n) begin
            rd_falls++;
            if (rd_falls == 1) byte0 = byte_sel; else byte1 = byte_sel;
            if (busy) rd_busy++;
            if (byte_sel && rdh_len < rdh_min) rdh_min = rdh_len;
            rdl_len = 1;
         end else if (!rd_n) begin
            rdl_len++;
         end
         if (!p_rd && rd_n) begin
            if (rdl_len < rdl_min) rdl_min = rdl_len;
            if (rdl_len > rdl_max) rdl_max = rdl_len;
            since_rd = 0; rdh_len = 1;
         end else begin
            since_rd++;
            if (rd_n) rdh_len++;
         end
         if (vld) begin
            if (vld_cnt < 4) smp[vld_cnt] = sample;
            vld_cnt++;
         end
         if (tmo) tmo_cnt++;
         p_cv = convst_n; p_rd = rd_n; p_clk = adc_clk;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_min(input string req, input int act, input int lim);
      n_chk++;
      if (act < lim) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected at least %0d", req, act, lim);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic pulse_start();
      @(negedge clk); #1 start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
   endtask

   task automatic wait_vld(input int n);
      int k = 0;
      while (vld_cnt < n && k < 4000) begin cyc(1); k++; end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      cyc(1);
      chk("R1 cs_n in reset", cs_n, 1); chk("R1 convst_n in reset", convst_n, 1);
      chk("R1 rd_n in reset", rd_n, 1); chk("R1 byte in reset", byte_sel, 0);
      chk("R1 valid in reset", vld, 0); chk("R1 timeout in reset", tmo, 0);
      @(negedge clk); #1 rst_n = 1'b1;
      cyc(1);
      chk("R1 cs_n after reset", cs_n, 1); chk("R1 convst_n after reset", convst_n, 1);
      chk("R1 rd_n after reset", rd_n, 1); chk("R1 valid after reset", vld, 0);
   endtask

   task automatic t_clock();
      int h = 0, l = 0;
      do @(negedge clk); while (adc_clk !== 1'b0);
      do @(negedge clk); while (adc_clk !== 1'b1);
      while (adc_clk === 1'b1) begin h++; @(negedge clk); end
      while (adc_clk === 1'b0) begin l++; @(negedge clk); end
      chk("R2 converter clock high cycles", h, HI);
      chk("R2 converter clock low cycles", l, LO);
   endtask

   task automatic t_word(input logic [15:0] c, input bit full);
      clr(); bmode = 1'b0; code = c;
      pulse_start(); wait_vld(1); cyc(GAP + 10);
      chk("R6 word sample", smp[0], c);
      chk("R8 one valid per conversion", vld_cnt, 1);
      chk("R6 single read", rd_falls, 1);
      if (full) begin
         chk("R6 byte low during read", byte0, 0);
         chk("R6 read low cycles", rdl_max, RDL);
         chk("R6 read low cycles min", rdl_min, RDL);
         chk("R4 convst low cycles", cvl_last, CVL);
         chk_min("R4 convst lead to clock rise", lead_min, LEAD);
         chk_min("R3 cs low before convst", cs_min, CSS + 1);
         chk("R5 no read while busy", rd_busy, 0);
         chk("R3 cs released after sequence", cs_n, 1);
      end
   endtask

   task automatic t_byte(input logic [15:0] c);
      clr(); bmode = 1'b1; code = c;
      pulse_start(); wait_vld(1); cyc(GAP + 10);
      chk("R7 byte-mode sample", smp[0], c);
      chk("R7 two reads", rd_falls, 2);
      chk("R7 first read byte select", byte0, 0);
      chk("R7 second read byte select", byte1, 1);
      chk_min("R7 read high between halves", rdh_min, RDH);
      chk("R7 read low cycles", rdl_max, RDL);
      chk("R5 no read while busy", rd_busy, 0);
      chk("R8 one valid per conversion", vld_cnt, 1);
      bmode = 1'b0;
   endtask

   task automatic t_ignore();
      clr(); bmode = 1'b0; code = 16'hC3A5;
      pulse_start(); cyc(100);
      bmode = 1'b1; pulse_start();
      wait_vld(1); cyc(300);
      chk("R9 start ignored mid-sequence", cf_cnt, 1);
      chk("R12 mode latched: one read", rd_falls, 1);
      chk("R12 mode latched: result", smp[0], 16'hC3A5);
      chk("R8 single valid", vld_cnt, 1);
      bmode = 1'b0;
   endtask

   task automatic t_free_run();
      clr(); bmode = 1'b0; code = 16'h0F00; incr = 16'h0123;
      @(negedge clk); #1 run = 1'b1;
      wait_vld(3);
      run = 1'b0;
      cyc(1500);
      chk("R10 free-run sample 0", smp[0], 16'h0F00);
      chk("R10 free-run sample 1", smp[1], 16'h1023);
      chk("R10 free-run sample 2", smp[2], 16'h1146);
      chk_min("R9 read-to-convst gap", gap_min, GAP);
      chk("R10 stops when run low", (cf_cnt == vld_cnt) ? 1 : 0, 1);
      incr = 16'h0;
   endtask

   task automatic t_timeout();
      clr(); stuck = 1;
      pulse_start(); cyc(1300);
      chk("R11 timeout pulse", tmo_cnt, 1);
      chk("R11 no valid on timeout", vld_cnt, 0);
      chk("R11 no read on timeout", rd_falls, 0);
      chk("R11 cs released", cs_n, 1);
      stuck = 0; active = 0; busy = 1'b0;
      cyc(5);
   endtask

   initial begin
      cyc(8);
      t_reset();
      t_clock();
      t_word(16'hBEEF, 1);
      t_word(16'h0000, 0);
      t_word(16'hFFFF, 0);
      t_byte(16'h1234);
      t_byte(16'h80FF);
      t_ignore();
      t_free_run();
      t_timeout();
      t_word(16'h7FFF, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      done = 1;
      $finish;
   end

   initial begin
      #600000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule